// File: doc/BRIEF.md
# Quarter-Wave Table Complex Oscillator

This block produces a stream of complex samples e^(−jθ) whose phase θ advances by a programmable integer step each sample. It is meant to feed a mixer that moves a received band down to zero frequency. The full waveform period is 24576 phase steps, so any integer multiple of the base frequency (clock rate over 24576) can be produced exactly. The phase accumulator therefore wraps at 24576 rather than at a power of two.

The core runs on a fast clock at twice the sample rate. A select input toggles on every fast cycle and marks the two halves of each sample period. Only the first quadrant of a cosine is stored: 6144 magnitudes, computed at elaboration. An angle fold maps every phase onto that quadrant and records the signs for I and Q. The single table port is read twice per sample, first for the cosine and then for the sine. A delay register brings the two reads back together, so that each I/Q pair leaves the block at the same time and stays stable for a whole sample period.

Top module: `qwave_nco`

## Requirements
- R1: On the fast-clock edge where enable is first seen high, the phase clears to 0. After that, the phase grows by the increment once per sample, on edges where select is high. Output sample k therefore corresponds to phase (k·inc) mod 24576, and a new enable rise restarts the sequence at phase 0.
- R2: The phase stays within 0..24575. When phase plus increment is 24576 or more, 24576 is subtracted. The increment is an unsigned value from 0 to 24575.
- R3: Outputs are 12-bit two's-complement values. With θ = 2π·phase/24576, i_o equals 2047·cos θ and q_o equals −2047·sin θ, each within 1 LSB.
- R4: Every phase is folded onto a first-quadrant cosine index from 0 to 6143, using strict comparisons against 6144, 12288 and 18432. The sine index is 6144 minus the cosine index. All four quadrants give outputs that match R3.
- R5: An index of 6144 is replaced by 6143, because the zero entry is not stored. The exact outputs are: phase 0 gives (2047, −1); phase 6144 gives (1, −2047); phase 12288 gives (−2047, −1); phase 18432 gives (−1, 2047).
- R6: Outputs and vld_o change only on fast edges where select is low, so each pair holds for two fast cycles.
- R7: vld_o rises on the fifth fast edge after the edge that first samples enable high, provided that edge has select high. After that, one new sample arrives per sample period while enable stays high.
- R8: Within six fast edges after enable goes low, vld_o is low.
- R9: While reset is held and right after it, vld_o, i_o and q_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock, twice the sample rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Half-period select; toggles every fast cycle |
| en_i | input | 1 | Run enable; a rising edge restarts at phase 0 |
| inc_i | input | 15 | Phase increment per sample, 0..24575 |
| vld_o | output | 1 | Output pair is valid |
| i_o | output | 12 | In-phase sample, signed |
| q_o | output | 12 | Quadrature sample, signed (conjugate sign) |

## Verification
On every cycle, the assertions check the following: the phase stays in range; the phase is frozen on select-low edges and cleared on an enable rise; the folded indices stay below 6144 and sum to 6144 or 6143; the table output sign follows the fold's sign flag; and the outputs hold across select-high edges. Other properties need whole scenarios and are checked by the bench: the numeric accuracy against a real-valued cosine and sine, the exact clamped values at the four quadrant boundaries, the wrap arithmetic for large and near-full-period increments, the five-edge start latency, and the restart at phase 0.

// File: rtl/qwave_nco_pkg.sv
package qwave_nco_pkg;

    localparam int unsigned DEF_PERIOD = 24576;
    localparam int unsigned DEF_PH_W   = 15;
    localparam int unsigned DEF_AMP_W  = 12;

    // modular add for operands already below the modulus
    function automatic int unsigned mod_add(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned m);
        int unsigned s;
        s = a + b;
        if (s >= m) begin
            s = s - m;
        end
        return s;
    endfunction

endpackage

// File: rtl/qwave_phase_acc.sv
module qwave_phase_acc
    import qwave_nco_pkg::*;
#(
    parameter int unsigned PERIOD = DEF_PERIOD,
    parameter int unsigned PH_W   = DEF_PH_W
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            sel_i,
    input  logic            en_i,
    input  logic [PH_W-1:0] inc_i,
    output logic [PH_W-1:0] phase_o,
    output logic            run_o
);

    localparam logic [PH_W-1:0] PER = PH_W'(PERIOD);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            en;
    } acc_t;

    acc_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d    = st_q;
        rise    = en_i && !st_q.en;
        st_d.en = en_i;
        if (rise) begin
            st_d.phase = '0;
        end else if (en_i && sel_i) begin
            st_d.phase = PH_W'(mod_add(int'(st_q.phase), int'(inc_i), PERIOD));
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign run_o   = en_i && st_q.en;

    AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.phase < PER);                                            // R2
    AST_PHASE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !st_q.en) |=> (st_q.phase == '0));                    // R1
    AST_PHASE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sel_i && !(en_i && !st_q.en)) |=> $stable(st_q.phase));      // R1

endmodule

// File: rtl/qwave_fold.sv
module qwave_fold #(
    parameter int unsigned PERIOD = 24576,
    parameter int unsigned PH_W   = 15,
    parameter int unsigned IDX_W  = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sel_i,
    input  logic [PH_W-1:0]  phase_i,
    input  logic             run_i,
    output logic [IDX_W-1:0] cos_idx_o,
    output logic [IDX_W-1:0] sin_idx_o,
    output logic             neg_c_o,
    output logic             neg_s_o,
    output logic             vld_o
);

    localparam logic [PH_W-1:0] PER = PH_W'(PERIOD);
    localparam logic [PH_W-1:0] Q1  = PH_W'(PERIOD / 4);
    localparam logic [PH_W-1:0] Q2  = PH_W'(PERIOD / 2);
    localparam logic [PH_W-1:0] Q3  = PH_W'((3 * PERIOD) / 4);

    typedef struct packed {
        logic [IDX_W-1:0] cidx;
        logic [IDX_W-1:0] sidx;
        logic             nc;
        logic             ns;
        logic             vld;
    } fold_t;

    fold_t st_d, st_q;
    logic [PH_W-1:0] c_full;
    logic [PH_W-1:0] s_full;
    logic            nc_w;
    logic            ns_w;

    always_comb begin
        if (phase_i > Q3) begin
            c_full = PER - phase_i;
            nc_w   = 1'b0;
            ns_w   = 1'b0;
        end else if (phase_i > Q2) begin
            c_full = phase_i - Q2;
            nc_w   = 1'b1;
            ns_w   = 1'b0;
        end else if (phase_i > Q1) begin
            c_full = Q2 - phase_i;
            nc_w   = 1'b1;
            ns_w   = 1'b1;
        end else begin
            c_full = phase_i;
            nc_w   = 1'b0;
            ns_w   = 1'b1;
        end
        s_full = Q1 - c_full;
        if (c_full == Q1) begin
            c_full = Q1 - 1'b1;
        end
        if (s_full == Q1) begin
            s_full = Q1 - 1'b1;
        end

        st_d = st_q;
        if (sel_i) begin
            st_d.cidx = IDX_W'(c_full);
            st_d.sidx = IDX_W'(s_full);
            st_d.nc   = nc_w;
            st_d.ns   = ns_w;
            st_d.vld  = run_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cos_idx_o = st_q.cidx;
    assign sin_idx_o = st_q.sidx;
    assign neg_c_o   = st_q.nc;
    assign neg_s_o   = st_q.ns;
    assign vld_o     = st_q.vld;

    AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.vld |-> (PH_W'(st_q.cidx) < Q1 && PH_W'(st_q.sidx) < Q1)); // R4
    AST_IDX_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.vld |-> ((PH_W'(st_q.cidx) + PH_W'(st_q.sidx) == Q1) ||
                      (PH_W'(st_q.cidx) + PH_W'(st_q.sidx) == Q1 - 1'b1))); // R5

endmodule

// File: rtl/qwave_qtr_rom.sv
module qwave_qtr_rom #(
    parameter int unsigned PERIOD = 24576,
    parameter int unsigned IDX_W  = 13,
    parameter int unsigned AMP_W  = 12
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    sel_i,
    input  logic [IDX_W-1:0]        cos_idx_i,
    input  logic [IDX_W-1:0]        sin_idx_i,
    input  logic                    neg_c_i,
    input  logic                    neg_s_i,
    output logic signed [AMP_W-1:0] val_o
);

    localparam int unsigned QTR   = PERIOD / 4;
    localparam int unsigned MAG_W = AMP_W - 1;
    localparam int unsigned FULL  = (1 << MAG_W) - 1;

    function automatic logic [MAG_W-1:0] cos_entry(input int k);
        real ang;
        ang = 2.0 * 3.14159265358979323846 * real'(k) / real'(PERIOD);
        return MAG_W'($rtoi(real'(FULL) * $cos(ang) + 0.5));
    endfunction

    logic [MAG_W-1:0] tbl [QTR];

    initial begin
        for (int k = 0; k < int'(QTR); k++) begin
            tbl[k] = cos_entry(k);
        end
    end

    typedef struct packed {
        logic signed [AMP_W-1:0] val;
    } rd_t;

    rd_t st_d, st_q;
    logic [IDX_W-1:0] addr;
    logic             neg;
    logic [MAG_W-1:0] mag;

    always_comb begin
        addr = sel_i ? sin_idx_i : cos_idx_i;
        neg  = sel_i ? neg_s_i : neg_c_i;
        mag  = tbl[addr];
        if (neg) begin
            st_d.val = -$signed({1'b0, mag});
        end else begin
            st_d.val = $signed({1'b0, mag});
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_o = st_q.val;

    AST_ROM_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        neg |=> (val_o <= 0));                                         // R3
    AST_ROM_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !neg |=> (val_o >= 0));                                        // R3

endmodule

// File: rtl/qwave_nco.sv
module qwave_nco
    import qwave_nco_pkg::*;
#(
    parameter int unsigned PERIOD = DEF_PERIOD,
    parameter int unsigned PH_W   = DEF_PH_W,
    parameter int unsigned AMP_W  = DEF_AMP_W
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    sel_i,
    input  logic                    en_i,
    input  logic [PH_W-1:0]         inc_i,
    output logic                    vld_o,
    output logic signed [AMP_W-1:0] i_o,
    output logic signed [AMP_W-1:0] q_o
);

    localparam int unsigned IDX_W = $clog2(PERIOD / 4);

    logic [PH_W-1:0]         phase;
    logic                    run;
    logic [IDX_W-1:0]        cidx;
    logic [IDX_W-1:0]        sidx;
    logic                    neg_c;
    logic                    neg_s;
    logic                    fold_vld;
    logic signed [AMP_W-1:0] rd_val;

    qwave_phase_acc #(.PERIOD(PERIOD), .PH_W(PH_W)) u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sel_i   (sel_i),
        .en_i    (en_i),
        .inc_i   (inc_i),
        .phase_o (phase),
        .run_o   (run)
    );

    qwave_fold #(.PERIOD(PERIOD), .PH_W(PH_W), .IDX_W(IDX_W)) u_fold (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sel_i     (sel_i),
        .phase_i   (phase),
        .run_i     (run),
        .cos_idx_o (cidx),
        .sin_idx_o (sidx),
        .neg_c_o   (neg_c),
        .neg_s_o   (neg_s),
        .vld_o     (fold_vld)
    );

    qwave_qtr_rom #(.PERIOD(PERIOD), .IDX_W(IDX_W), .AMP_W(AMP_W)) u_rom (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sel_i     (sel_i),
        .cos_idx_i (cidx),
        .sin_idx_i (sidx),
        .neg_c_i   (neg_c),
        .neg_s_i   (neg_s),
        .val_o     (rd_val)
    );

    typedef struct packed {
        logic signed [AMP_W-1:0] hold;
        logic                    hold_vld;
        logic signed [AMP_W-1:0] out_i;
        logic signed [AMP_W-1:0] out_q;
        logic                    out_vld;
    } align_t;

    align_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_i) begin
            // the cosine read lands here; park it until the sine arrives
            st_d.hold     = rd_val;
            st_d.hold_vld = fold_vld;
        end else begin
            st_d.out_i   = st_q.hold;
            st_d.out_q   = rd_val;
            st_d.out_vld = st_q.hold_vld;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o = st_q.out_vld;
    assign i_o   = st_q.out_i;
    assign q_o   = st_q.out_q;

    AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_i |=> ($stable(i_o) && $stable(q_o) && $stable(vld_o)));    // R6

endmodule

// File: tb/qwave_nco_tb.sv
module qwave_nco_tb;

    localparam int  NPER = 24576;
    localparam real PI   = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sel = 1'b0;
    logic               en = 1'b0;
    logic [14:0]        inc = '0;
    logic               vld;
    logic signed [11:0] i_s;
    logic signed [11:0] q_s;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    qwave_nco u_dut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .sel_i  (sel),
        .en_i   (en),
        .inc_i  (inc),
        .vld_o  (vld),
        .i_o    (i_s),
        .q_o    (q_s)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) sel = 1'b0;
            else        sel = ~sel;
        end
    end

    function automatic real ref_i(input int p);
        return 2047.0 * $cos(2.0 * PI * real'(p) / real'(NPER));
    endfunction

    function automatic real ref_q(input int p);
        return -2047.0 * $sin(2.0 * PI * real'(p) / real'(NPER));
    endfunction

    function automatic real rabs(input real x);
        return (x < 0.0) ? -x : x;
    endfunction

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_near(input string req, input int p, input int ai, input int aq);
        real ei, eq;
        ei = ref_i(p);
        eq = ref_q(p);
        n_chk++;
        if (rabs(real'(ai) - ei) > 1.0001 || rabs(real'(aq) - eq) > 1.0001) begin
            n_bad++;
            $display("FAIL %s phase %0d: actual (%0d,%0d) expected (%0.2f,%0.2f)",
                     req, p, ai, aq, ei, eq);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic burst(input int step, input int nsamp, input string req);
        int j, e, last_i, last_q, p;
        do tick(); while (sel != 1'b0);
        en  = 1'b1;
        inc = 15'(step);
        tick();
        for (int k = 1; k <= 4; k++) begin
            tick();
            if (k == 4) chk_eq("R7", "vld before latency", int'(vld), 0);
        end
        j = 0; e = 0; last_i = 0; last_q = 0;
        while (j < nsamp && e < 4 * nsamp + 20) begin
            tick();
            e++;
            if (j == 0 && e == 1) chk_eq("R7", "vld at fifth edge", int'(vld), 1);
            if (sel == 1'b0 && vld) begin
                p = int'((longint'(j) * longint'(step)) % NPER);
                last_i = int'(i_s);
                last_q = int'(q_s);
                if (j == 0) begin
                    chk_eq("R1", "restart I", last_i, 2047);
                    chk_eq("R1", "restart Q", last_q, -1);
                end else if (req == "R5") begin
                    case (j % 4)
                        0: begin chk_eq("R5", "I q0", last_i, 2047);  chk_eq("R5", "Q q0", last_q, -1);    end
                        1: begin chk_eq("R5", "I q1", last_i, 1);     chk_eq("R5", "Q q1", last_q, -2047); end
                        2: begin chk_eq("R5", "I q2", last_i, -2047); chk_eq("R5", "Q q2", last_q, -1);    end
                        default: begin chk_eq("R5", "I q3", last_i, -1); chk_eq("R5", "Q q3", last_q, 2047); end
                    endcase
                end else begin
                    chk_near(req, p, last_i, last_q);
                end
                j++;
            end else if (sel == 1'b1 && j > 0 && (j % 8) == 1) begin
                chk_eq("R6", "I hold", int'(i_s), last_i);
                chk_eq("R6", "Q hold", int'(q_s), last_q);
            end
        end
        chk_eq("R7", "samples delivered", j, nsamp);
        en = 1'b0;
        for (int k = 0; k < 6; k++) tick();
        chk_eq("R8", "vld after disable", int'(vld), 0);
        tick();
        tick();
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int r;
        void'($urandom(32'd90210));
        repeat (4) @(posedge clk);
        #2;
        chk_eq("R9", "vld in reset", int'(vld), 0);
        chk_eq("R9", "I in reset", int'(i_s), 0);
        chk_eq("R9", "Q in reset", int'(q_s), 0);
        rst_n = 1'b1;
        tick();
        chk_eq("R9", "vld after reset", int'(vld), 0);

        burst(0,     12, "R3");
        burst(1,     24, "R3");
        burst(6144,  24, "R5");
        burst(8192,  24, "R2");   // sum hits exactly 24576
        burst(3000,  40, "R4");
        burst(24575, 24, "R2");   // wraps every sample
        burst(18432, 16, "R4");
        burst(12288, 16, "R4");
        for (int k = 0; k < 8; k++) begin
            r = int'($urandom % NPER);
            burst(r, 30, "R3");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule